// File: doc/BRIEF.md
# Raster Line Event Unit

This unit follows the line number reported by a display timing generator and turns chosen line positions into events. Four independent compare sources each latch a sticky status bit when the raster reaches their programmed line. A mask selects which of those bits drive a single level-sensitive interrupt request, and software retires a bit by writing a one to its position in a separate clear register.

Next to the interrupt sources, the unit emits two single-clock strobes for an external context-reload engine. One is for register sets that take effect immediately (single-buffered). The other is for sets that are latched at a frame boundary (double-buffered). Each strobe fires at its own programmable line, and only while the timing generator reports that it is running. A common setup puts the double-buffered strobe near 99% of the last visible line, one interrupt source at about 90% to kick the reload engine, and another at line 0 as a vertical-blank event.

Top module: `lpi_line_irq`

## Requirements
- R1: While reset is held, and in the first cycle after it, status is 0, the interrupt request is low and both strobes are low.
- R2: When lineStart is high and curLine equals the compare line of source i, status bit i is 1 from the next clock edge and stays set until it is cleared.
- R3: A source sets its status at most once per frame. After it fires, a later match does nothing until a cycle with frameStart high re-arms it.
- R4: A write to word address 1 clears every status bit whose data bit (3:0) is 1. Bits written as 0 keep their value.
- R5: When a match and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R6: The interrupt request equals the OR over i of status[i] AND mask[i]. The mask is written at word address 0, bits 3:0, and a 1 enables a source.
- R7: dbTrig is high for exactly one clock, in the cycle after lineStart, when curLine equals the double-buffer line (word address 2, bits 12:0).
- R8: sbTrig is high for exactly one clock, in the cycle after lineStart, when curLine equals the single-buffer line (word address 2, bits 28:16).
- R9: While running is low, neither strobe fires, even on a matching line.
- R10: A write to word address 3 (the status position) has no effect on status.
- R11: The compare line of source i is written at word address 4+i, bits 28:16. Bits 12:0 of that word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curLine | input | 13 | Current raster line |
| lineStart | input | 1 | One-cycle pulse on the first pixel of a line |
| frameStart | input | 1 | One-cycle pulse on the first pixel of line 0 |
| running | input | 1 | Timing generator is active |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register word address |
| wrData | input | 32 | Register write data |
| irqOut | output | 1 | Level interrupt request |
| lineStatus | output | 4 | Sticky per-source status |
| sbTrig | output | 1 | Single-buffer reload strobe |
| dbTrig | output | 1 | Double-buffer reload strobe |

## Verification
The assertions take for granted that lineStart is a single-cycle pulse with idle cycles between pulses, and that frameStart only ever appears together with lineStart on line 0. The pulse-width checks on the strobes depend on the first assumption, and the re-arm check depends on the second. The stimulus comes from a modelled raster of eight lines, each three or more cycles long, with frameStart raised only on the line-0 start. Register writes go in the idle cycles, except for the one deliberate write that collides with a match.

// File: rtl/lpi_pkg.sv
package lpi_pkg;
  parameter int unsigned SRC_N  = 4;
  parameter int unsigned LINE_W = 13;

  typedef struct packed {
    logic [SRC_N-1:0] setVec;
    logic [SRC_N-1:0] clrVec;
    logic             sbFire;
    logic             dbFire;
  } lpiStrobe_t;
endpackage

// File: rtl/lpi_ctrl.sv
module lpi_ctrl
  import lpi_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINE_W-1:0] curLine,
  input  logic              lineStart,
  input  logic              frameStart,
  input  logic              running,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output lpiStrobe_t        strb,
  output logic [SRC_N-1:0]  maskOut
);
  localparam int unsigned FLD_LO    = 0;
  localparam int unsigned FLD_HI    = 16;
  localparam int unsigned LINE_BASE = 4;
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTX  = ADDR_W'(2);

  logic [LINE_W-1:0] cmpLine [SRC_N];
  logic [LINE_W-1:0] sbLine, dbLine;
  logic [SRC_N-1:0]  maskReg, armed, hitVec;
  logic              unusedWr;

  assign unusedWr = ^wrData;

  always_comb begin
    for (int i = 0; i < SRC_N; i++) begin
      hitVec[i] = lineStart && (curLine == cmpLine[i]) && (armed[i] || frameStart);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
      sbLine  <= '0;
      dbLine  <= '0;
      armed   <= '1;
      for (int i = 0; i < SRC_N; i++) cmpLine[i] <= '0;
    end else begin
      if (wrEn && wrAddr == A_MASK) maskReg <= wrData[SRC_N-1:0];
      if (wrEn && wrAddr == A_CTX) begin
        dbLine <= wrData[FLD_LO +: LINE_W];
        sbLine <= wrData[FLD_HI +: LINE_W];
      end
      for (int i = 0; i < SRC_N; i++) begin
        if (wrEn && wrAddr == ADDR_W'(LINE_BASE + i)) cmpLine[i] <= wrData[FLD_HI +: LINE_W];
      end
      armed <= (frameStart ? '1 : armed) & ~hitVec;
    end
  end

  always_comb begin
    strb.setVec = hitVec;
    strb.clrVec = (wrEn && wrAddr == A_CLR) ? wrData[SRC_N-1:0] : '0;
    strb.sbFire = lineStart && running && (curLine == sbLine);
    strb.dbFire = lineStart && running && (curLine == dbLine);
  end

  assign maskOut = maskReg;

  // R3
  frame_line_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (lineStart && curLine == '0));

  for (genvar g = 0; g < SRC_N; g++) begin : gArm
    // R3
    rearm_on_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(armed[g]) |-> $past(frameStart));
  end
endmodule

// File: rtl/lpi_dpath.sv
module lpi_dpath
  import lpi_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  lpiStrobe_t       strb,
  input  logic [SRC_N-1:0] maskIn,
  output logic [SRC_N-1:0] status,
  output logic             irqOut,
  output logic             sbTrig,
  output logic             dbTrig
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= '0;
      sbTrig <= 1'b0;
      dbTrig <= 1'b0;
    end else begin
      status <= (status & ~strb.clrVec) | strb.setVec;
      sbTrig <= strb.sbFire;
      dbTrig <= strb.dbFire;
    end
  end

  assign irqOut = |(status & maskIn);

  for (genvar g = 0; g < SRC_N; g++) begin : gStat
    // R2
    status_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(status[g]) |-> $past(strb.setVec[g]));
    // R4
    status_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(status[g]) |-> ($past(strb.clrVec[g]) && !$past(strb.setVec[g])));
  end

  // R8
  sb_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sbTrig |=> !sbTrig);
  // R7
  db_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dbTrig |=> !dbTrig);
  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(|strb.setVec) || (maskIn != $past(maskIn))));
endmodule

// File: rtl/lpi_line_irq.sv
module lpi_line_irq
  import lpi_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINE_W-1:0] curLine,
  input  logic              lineStart,
  input  logic              frameStart,
  input  logic              running,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              irqOut,
  output logic [SRC_N-1:0]  lineStatus,
  output logic              sbTrig,
  output logic              dbTrig
);
  lpiStrobe_t       strb;
  logic [SRC_N-1:0] maskVec;

  lpi_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .curLine(curLine), .lineStart(lineStart),
    .frameStart(frameStart), .running(running), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .strb(strb), .maskOut(maskVec)
  );

  lpi_dpath uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .maskIn(maskVec),
    .status(lineStatus), .irqOut(irqOut), .sbTrig(sbTrig), .dbTrig(dbTrig)
  );
endmodule

// File: tb/sim_lpi_line_irq.sv
module sim_lpi_line_irq;
  localparam int NL = 8;
  localparam int H  = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] curLine = '0;
  logic        lineStart = 1'b0, frameStart = 1'b0, running = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        irq, sbTrig, dbTrig;
  logic [3:0]  status;

  int nChk = 0, nFail = 0;
  int cmpB [4];
  int sbB = 0, dbB = 0;
  logic [3:0] maskB = '0, expStat = '0, armB = 4'hF;

  lpi_line_irq u0 (
    .clk(clk), .rstN(rstN), .curLine(curLine), .lineStart(lineStart),
    .frameStart(frameStart), .running(running), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .irqOut(irq), .lineStatus(status), .sbTrig(sbTrig), .dbTrig(dbTrig)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic modelHit(input int l, input bit fs);
    logic [3:0] hits = '0;
    for (int i = 0; i < 4; i++) if (cmpB[i] == l && (armB[i] || fs)) hits[i] = 1'b1;
    expStat = expStat | hits;
    armB = (fs ? 4'hF : armB) & ~hits;
  endtask

  task automatic runLine(input int l, input bit fs, input bit run);
    @(negedge clk);
    curLine = 13'(l); lineStart = 1'b1; frameStart = fs; running = run;
    modelHit(l, fs);
    @(negedge clk);
    lineStart = 1'b0; frameStart = 1'b0;
    chk(status == expStat, "R2 status after line start", 32'(status), 32'(expStat));
    chk(irq == |(expStat & maskB), "R6 irq level", 32'(irq), 32'(|(expStat & maskB)));
    chk(dbTrig == (run && l == dbB), "R7 double-buffer strobe", 32'(dbTrig), 32'(run && l == dbB));
    chk(sbTrig == (run && l == sbB), "R8 single-buffer strobe", 32'(sbTrig), 32'(run && l == sbB));
    if (!run) chk(!sbTrig && !dbTrig, "R9 strobes while stopped", {sbTrig, dbTrig}, 32'd0);
    for (int k = 1; k < H; k++) begin
      @(negedge clk);
      chk(!dbTrig, "R7 pulse width", 32'(dbTrig), 32'd0);
      chk(!sbTrig, "R8 pulse width", 32'(sbTrig), 32'd0);
    end
  endtask

  task automatic runFrame(input bit run);
    for (int l = 0; l < NL; l++) runLine(l, l == 0, run);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 4; i++) cmpB[i] = 0;
    repeat (3) @(negedge clk);
    chk(status == 0 && !irq && !sbTrig && !dbTrig, "R1 in reset", {status, irq, sbTrig, dbTrig}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(status == 0 && !irq && !sbTrig && !dbTrig, "R1 after reset", {status, irq, sbTrig, dbTrig}, 32'd0);

    for (int c = 0; c < NL; c++) begin
      for (int i = 0; i < 4; i++) begin
        cmpB[i] = (c + 3 * i) % NL;
        // R11: decoy line in bits 12:0 must be ignored
        wr(4 + i, 32'((cmpB[i] << 16) | ((cmpB[i] + 1) % NL)));
      end
      maskB = 4'(c * 5 + 1);
      wr(0, 32'(maskB));
      sbB = c; dbB = NL - 1 - c;
      wr(2, 32'((sbB << 16) | dbB));
      wr(1, 32'hF); expStat = '0;
      @(negedge clk);
      chk(status == 0, "R4 clear all", 32'(status), 32'd0);
      runFrame(c != 3);
      chk(status == expStat, "R11 compare field position", 32'(status), 32'(expStat));
      wr(1, 32'(4'(c + 6)));
      expStat = expStat & ~4'(c + 6);
      @(negedge clk);
      chk(status == expStat, "R4 partial clear", 32'(status), 32'(expStat));
    end

    // R3: once per frame, re-armed by frameStart
    cmpB[0] = 5; wr(4, 32'(5 << 16));
    wr(1, 32'hF); expStat = '0;
    runLine(5, 1'b0, 1'b1);
    chk(status[0] == 1'b0, "R3 no second hit in frame", 32'(status), 32'(expStat));
    runLine(0, 1'b1, 1'b1);
    runLine(5, 1'b0, 1'b1);
    chk(status[0] == 1'b1, "R3 re-armed after frame start", 32'(status), 32'(expStat));

    // R5: set and clear in same cycle
    runLine(0, 1'b1, 1'b1);
    @(negedge clk);
    curLine = 13'd5; lineStart = 1'b1; running = 1'b1;
    wrEn = 1'b1; wrAddr = 3'd1; wrData = 32'hF;
    expStat = '0;
    modelHit(5, 1'b0);
    @(negedge clk);
    lineStart = 1'b0; wrEn = 1'b0;
    chk(status == expStat && status[0], "R5 set beats clear", 32'(status), 32'(expStat));

    // R10: write at status position ignored
    wr(3, 32'hFFFF_FFFF);
    @(negedge clk);
    chk(status == expStat, "R10 status write ignored", 32'(status), 32'(expStat));

    // R6: mask gating
    maskB = 4'h0; wr(0, 32'h0);
    @(negedge clk);
    chk(irq == 1'b0, "R6 all masked", 32'(irq), 32'd0);
    maskB = 4'hF; wr(0, 32'hF);
    @(negedge clk);
    chk(irq == |expStat, "R6 all enabled", 32'(irq), 32'(|expStat));

    // R9: stopped frame with matching strobe lines
    runFrame(1'b0);
    finishRun();
  end
endmodule